// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block gathers level-sensitive interrupt requests from two banks and drives a single active-high request line to the processor. The primary bank has 40 sources. The secondary bank has 32 sources, and its combined active request takes the place of primary source 0. Each source has a sticky pending flag and an enable bit. Software changes enables only through separate write-one-to-set and write-one-to-clear registers. It clears pending flags through a write-one-to-acknowledge register.

To find the highest-priority primary source, software reads a priority index register. A value of 0 means no numbered primary source is active, and software should then read the secondary status word. An array of per-channel mapping registers and a few plain mode words complete the register space. All accesses use a simple 32-bit bus. Read data is registered and appears in the cycle after the address is presented.

Top module: `casc_intc`

## Requirements
- R1: After reset, all enables and pending flags are 0 and `cpu_irq` is 0. Mapping register n reads back the value n.
- R2: A pending flag is set on any cycle in which its input is high. It stays set after the input falls, until an acknowledge write with a 1 in its bit clears it. If the input is still high, the flag sets again on the next cycle.
- R3: Primary registers are laid out at slot*0x10 + word*4, where word = index/32. Enable-set is slot 2 and enable-clear is slot 3. Only bit positions written as 1 change, and reading either slot returns the current enable mask. In word 1, only bits 7:0 exist; writes to higher bits are ignored and those bits read 0.
- R4: `cpu_irq` is a registered OR of (primary pending AND enable). It rises one cycle after the pending flag that causes it.
- R5: Address 0x40 returns, in bits 5:0, the lowest-numbered primary source from 1 upward that is both pending and enabled. It returns 0 when no such source exists, including when only source 0 is active.
- R6: The input of primary source 0 is the OR of all secondary pending-and-enabled bits. The secondary status word at 0x80 reads as secondary pending AND enable.
- R7: Secondary registers are: acknowledge at 0x88, enable-set at 0x90 and enable-clear at 0x98, all write-one-to-act. Reading 0x90 or 0x98 returns the secondary enable mask.
- R8: Mapping register n sits at 0x200 + 4*n for n = 0..39. Each holds a 6-bit value that can be read and written.
- R9: The primary mode words at slots 5 and 6 and the control word at 0x44 are read/write storage. Writing them has no effect on `cpu_irq`.
- R10: `bus_rdata` is registered and reflects the address one cycle earlier. Write-only and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pri_req | input | 39 | Primary requests for sources 39..1 |
| sec_req | input | 32 | Secondary requests |
| cpu_irq | output | 1 | Registered request to the processor |

## Verification
The hardest state to reach is a cascaded request that must travel through two pending stages, secondary flag then primary flag 0, before `cpu_irq` rises. Reaching it correctly also requires clearing both levels in the right order, since acknowledging primary 0 while the secondary flag is still set just lets the flag set again. The stimulus acknowledges the secondary bank first and the primary bank afterwards. It then pulses random request vectors for one cycle under random enable masks, so the pending flags must hold each pulse. Finally it compares the index, the secondary status and the processor line with values computed in the bench. Directed cases cover a request held high through an acknowledge, source 0 active on its own, and writes to the nonexistent upper bits of the primary bank.

// File: rtl/casc_intc_pkg.sv
package casc_intc_pkg;
  localparam int SLOT_STRIDE = 16;
  localparam int SL_ACK      = 1;
  localparam int SL_ESET     = 2;
  localparam int SL_ECLR     = 3;
  localparam int SL_MODE     = 5;
  localparam int SL_TYPE     = 6;
  localparam int ADR_PIDX    = 'h40;
  localparam int ADR_CTRL    = 'h44;
  localparam int SEC_BASE    = 'h80;
  localparam int SEC_STRIDE  = 8;
  localparam int MAP_BASE    = 'h200;
endpackage

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic [N-1:0] set_m,
  input  logic [N-1:0] clr_m,
  input  logic [N-1:0] ack_m,
  output logic [N-1:0] pend,
  output logic [N-1:0] en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      en   <= '0;
    end else begin
      pend <= (pend | req) & ~ack_m;
      en   <= (en | set_m) & ~clr_m;
    end
  end
endmodule

// File: rtl/intc_lowest.sv
module intc_lowest #(
  parameter int N = 40,
  parameter int W = 6
) (
  input  logic [N-1:0] act,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 1; i--) begin
      if (act[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/intc_chmap.sv
module intc_chmap #(
  parameter int N    = 40,
  parameter int W    = 6,
  parameter int AW   = 10,
  parameter int BASE = 'h200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          hit
);
  localparam int IW = $clog2(N);
  logic [W-1:0]  map_q [N];
  logic [AW-1:0] off;
  logic [IW-1:0] sel;

  assign off = addr - AW'(BASE);
  assign hit = (addr >= AW'(BASE)) && (addr < AW'(BASE + 4 * N)) && (addr[1:0] == 2'b00);
  assign sel = IW'(off >> 2);

  always_ff @(posedge clk) begin
    for (int n = 0; n < N; n++) begin
      if (rst) map_q[n] <= W'(n);
      else if (we && hit && sel == IW'(n)) map_q[n] <= wdata[W-1:0];
    end
  end

  assign rdata = hit ? 32'(map_q[sel]) : 32'd0;
endmodule

// File: rtl/casc_intc.sv
module casc_intc
  import casc_intc_pkg::*;
#(
  parameter int PRI_N  = 40,
  parameter int SEC_N  = 32,
  parameter int ADDR_W = 10,
  parameter int MAP_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [PRI_N-1:1]  pri_req,
  input  logic [SEC_N-1:0]  sec_req,
  output logic              cpu_irq
);
  localparam int PRI_WD = (PRI_N + 31) / 32;
  localparam int PAD    = PRI_WD * 32;
  localparam int IDX_W  = $clog2(PRI_N);
  localparam logic [PAD-1:0] VALID = PAD'({PRI_N{1'b1}});

  function automatic logic [ADDR_W-1:0] pa(input int slot, input int w);
    return ADDR_W'(slot * SLOT_STRIDE + w * 4);
  endfunction

  function automatic logic [ADDR_W-1:0] sa(input int slot);
    return ADDR_W'(SEC_BASE + slot * SEC_STRIDE);
  endfunction

  logic [PAD-1:0]   ack_pad, set_pad, clr_pad;
  logic [PAD-1:0]   mode_q, type_q;
  logic [PRI_N-1:0] pri_ack, pri_set, pri_clr, pri_pend, pri_en, pri_in, pri_act;
  logic [SEC_N-1:0] sec_ack, sec_set, sec_clr, sec_pend, sec_en, sec_act;
  logic [31:0]      ctrl_q, map_rd, rd_next;
  logic             map_hit;
  logic [IDX_W-1:0] win_idx;

  always_comb begin
    ack_pad = '0;
    set_pad = '0;
    clr_pad = '0;
    for (int w = 0; w < PRI_WD; w++) begin
      if (bus_we && bus_addr == pa(SL_ACK, w))  ack_pad[w*32 +: 32] = bus_wdata;
      if (bus_we && bus_addr == pa(SL_ESET, w)) set_pad[w*32 +: 32] = bus_wdata;
      if (bus_we && bus_addr == pa(SL_ECLR, w)) clr_pad[w*32 +: 32] = bus_wdata;
    end
  end

  assign pri_ack = ack_pad[PRI_N-1:0];
  assign pri_set = set_pad[PRI_N-1:0];
  assign pri_clr = clr_pad[PRI_N-1:0];
  assign sec_ack = (bus_we && bus_addr == sa(1)) ? bus_wdata[SEC_N-1:0] : '0;
  assign sec_set = (bus_we && bus_addr == sa(2)) ? bus_wdata[SEC_N-1:0] : '0;
  assign sec_clr = (bus_we && bus_addr == sa(3)) ? bus_wdata[SEC_N-1:0] : '0;

  intc_bank #(.N(SEC_N)) u_sec (
    .clk(clk), .rst(rst), .req(sec_req), .set_m(sec_set), .clr_m(sec_clr),
    .ack_m(sec_ack), .pend(sec_pend), .en(sec_en)
  );

  assign sec_act = sec_pend & sec_en;
  assign pri_in  = {pri_req, |sec_act};

  intc_bank #(.N(PRI_N)) u_pri (
    .clk(clk), .rst(rst), .req(pri_in), .set_m(pri_set), .clr_m(pri_clr),
    .ack_m(pri_ack), .pend(pri_pend), .en(pri_en)
  );

  assign pri_act = pri_pend & pri_en;

  intc_lowest #(.N(PRI_N), .W(IDX_W)) u_win (.act(pri_act), .idx(win_idx));

  intc_chmap #(.N(PRI_N), .W(MAP_W), .AW(ADDR_W), .BASE(MAP_BASE)) u_map (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(map_rd), .hit(map_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      type_q <= '0;
      ctrl_q <= '0;
    end else begin
      for (int w = 0; w < PRI_WD; w++) begin
        if (bus_we && bus_addr == pa(SL_MODE, w)) mode_q[w*32 +: 32] <= bus_wdata;
        if (bus_we && bus_addr == pa(SL_TYPE, w)) type_q[w*32 +: 32] <= bus_wdata;
      end
      if (bus_we && bus_addr == ADDR_W'(ADR_CTRL)) ctrl_q <= bus_wdata;
    end
  end

  always_comb begin
    logic [PAD-1:0] en_pad, mode_v, type_v;
    en_pad  = PAD'(pri_en);
    mode_v  = mode_q & VALID;
    type_v  = type_q & VALID;
    rd_next = map_rd;
    for (int w = 0; w < PRI_WD; w++) begin
      if (bus_addr == pa(SL_ESET, w) || bus_addr == pa(SL_ECLR, w)) rd_next = en_pad[w*32 +: 32];
      if (bus_addr == pa(SL_MODE, w)) rd_next = mode_v[w*32 +: 32];
      if (bus_addr == pa(SL_TYPE, w)) rd_next = type_v[w*32 +: 32];
    end
    if (bus_addr == ADDR_W'(ADR_PIDX)) rd_next = 32'(win_idx);
    if (bus_addr == ADDR_W'(ADR_CTRL)) rd_next = ctrl_q;
    if (bus_addr == sa(0)) rd_next = 32'(sec_act);
    if (bus_addr == sa(2) || bus_addr == sa(3)) rd_next = 32'(sec_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      cpu_irq   <= 1'b0;
    end else begin
      bus_rdata <= rd_next;
      cpu_irq   <= |pri_act;
    end
  end
endmodule

// File: rtl/casc_intc_chk.sv
module casc_intc_chk #(
  parameter int PRI_N = 40,
  parameter int SEC_N = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_irq,
  input logic [PRI_N-1:0] pri_pend,
  input logic [PRI_N-1:0] pri_en,
  input logic [PRI_N-1:0] pri_ack,
  input logic [PRI_N-1:0] pri_clr,
  input logic [SEC_N-1:0] sec_pend,
  input logic [SEC_N-1:0] sec_en,
  input logic [SEC_N-1:0] sec_ack,
  input logic [SEC_N-1:0] sec_req
);
  AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> (!cpu_irq && pri_en == '0 && sec_pend == '0)); // R1
  AST_SEC_LATCH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sec_pend & $past(sec_req & ~sec_ack)) == $past(sec_req & ~sec_ack))); // R2
  AST_PRI_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pri_pend & $past(pri_pend & ~pri_ack)) == $past(pri_pend & ~pri_ack))); // R2
  AST_EN_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (|pri_clr) |=> ((pri_en & $past(pri_clr)) == '0)); // R3
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    (|(pri_pend & pri_en)) |=> cpu_irq); // R4
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|(pri_pend & pri_en)) |=> !cpu_irq); // R4
  AST_CASCADE: assert property (@(posedge clk) disable iff (rst)
    ((|(sec_pend & sec_en)) && !pri_ack[0]) |=> pri_pend[0]); // R6
endmodule

bind casc_intc casc_intc_chk #(.PRI_N(PRI_N), .SEC_N(SEC_N)) u_chk (
  .clk(clk), .rst(rst), .cpu_irq(cpu_irq), .pri_pend(pri_pend), .pri_en(pri_en),
  .pri_ack(pri_ack), .pri_clr(pri_clr), .sec_pend(sec_pend), .sec_en(sec_en),
  .sec_ack(sec_ack), .sec_req(sec_req)
);

// File: tb/sim_casc_intc.sv
module sim_casc_intc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [39:1] pri_req = '0;
  logic [31:0] sec_req = '0;
  logic        cpu_irq;
  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  casc_intc u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pri_req(pri_req), .sec_req(sec_req), .cpu_irq(cpu_irq)
  );

  function automatic logic [9:0] pa(input int slot, input int w);
    return 10'(slot * 16 + w * 4);
  endfunction

  function automatic int lowest(input logic [39:0] act);
    for (int i = 1; i < 40; i++) if (act[i]) return i;
    return 0;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic clear_all();
    wr(10'h88, 32'hFFFF_FFFF);
    wr(pa(1, 0), 32'hFFFF_FFFF);
    wr(pa(1, 1), 32'h0000_00FF);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", 64'(cpu_irq), 64'd0);
    rd(pa(2, 0), rv); check("R1 en0", 64'(rv), 64'd0);
    rd(pa(3, 1), rv); check("R1 en1", 64'(rv), 64'd0);
    rd(10'h90, rv);   check("R1 sec en", 64'(rv), 64'd0);
    rd(10'h40, rv);   check("R1 pidx", 64'(rv), 64'd0);
    rd(10'h200, rv);  check("R1 map0", 64'(rv), 64'd0);
    rd(10'h214, rv);  check("R1 map5", 64'(rv), 64'd5);
    rd(10'h29C, rv);  check("R1 map39", 64'(rv), 64'd39);

    // R4 timing of cpu_irq after a one-cycle pulse on source 5
    wr(pa(2, 0), 32'h20);
    @(negedge clk); pri_req[5] = 1'b1;
    @(negedge clk); pri_req[5] = 1'b0;
    check("R4 irq one cycle after pend", 64'(cpu_irq), 64'd0);
    @(negedge clk);
    check("R4 irq raised", 64'(cpu_irq), 64'd1);
    rd(10'h40, rv); check("R5 pidx=5", 64'(rv), 64'd5);
    rd(pa(3, 0), rv); check("R3 clr slot reads mask", 64'(rv), 64'h20);
    wr(pa(1, 0), 32'h20);
    @(negedge clk);
    check("R2 ack clears", 64'(cpu_irq), 64'd0);

    // R3 upper word: only bits 7:0 exist
    wr(pa(2, 1), 32'hFFFF_FF00);
    rd(pa(2, 1), rv); check("R3 upper bits ignored", 64'(rv), 64'd0);
    wr(pa(2, 1), 32'h0000_0081);
    wr(pa(3, 1), 32'h0000_0001);
    rd(pa(2, 1), rv); check("R3 clr only written ones", 64'(rv), 64'h80);

    // R2/R7 held request survives acknowledge
    wr(10'h90, 32'h8);
    wr(pa(3, 0), 32'hFFFF_FFFF);
    @(negedge clk); sec_req[3] = 1'b1;
    repeat (2) @(negedge clk);
    wr(10'h88, 32'h8);
    rd(10'h80, rv); check("R2 re-set while high", 64'(rv), 64'h8);
    sec_req[3] = 1'b0;
    wr(10'h88, 32'h8);
    rd(10'h80, rv); check("R7 ack after drop", 64'(rv), 64'h0);

    // R5/R6 only source 0 active: index 0, irq high
    wr(pa(1, 0), 32'hFFFF_FFFF);
    wr(pa(2, 0), 32'h1);
    @(negedge clk); sec_req[3] = 1'b1;
    @(negedge clk); sec_req[3] = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 cascade irq", 64'(cpu_irq), 64'd1);
    rd(10'h40, rv); check("R5 only source0 -> 0", 64'(rv), 64'd0);
    rd(10'h98, rv); check("R7 sec clr reads mask", 64'(rv), 64'h8);

    // R8 mapping, R9 mode words, R10 unmapped
    wr(pa(3, 0), 32'hFFFF_FFFF);
    clear_all();
    wr(10'h2A8 - 10'h0C, 32'h7);
    rd(10'h29C, rv); check("R8 map write", 64'(rv), 64'd7);
    rd(10'h298, rv); check("R8 neighbour", 64'(rv), 64'd38);
    wr(pa(5, 0), 32'hDEAD_BEEF);
    wr(pa(6, 1), 32'h1234_56AB);
    wr(10'h44, 32'hCAFE_0001);
    rd(pa(5, 0), rv); check("R9 mode word", 64'(rv), 64'hDEAD_BEEF);
    rd(pa(6, 1), rv); check("R9 type word upper", 64'(rv), 64'hAB);
    rd(10'h44, rv);   check("R9 ctrl word", 64'(rv), 64'hCAFE_0001);
    check("R9 irq untouched", 64'(cpu_irq), 64'd0);
    rd(10'h300, rv);  check("R10 unmapped", 64'(rv), 64'd0);
    rd(10'h88, rv);   check("R10 ack reads 0", 64'(rv), 64'd0);

    // Random: pulse request vectors under random enable masks
    for (int it = 0; it < 60; it++) begin
      logic [39:0] en_p, pend_p, set_p, clr_p;
      logic [31:0] en_s, set_s, clr_s, rs;
      logic [39:1] rp;
      set_p = {$urandom(), $urandom()};
      clr_p = {$urandom(), $urandom()} & {$urandom(), $urandom()};
      set_s = $urandom();
      clr_s = $urandom() & $urandom();
      rp = {$urandom(), $urandom()};
      rs = $urandom() & $urandom();
      en_p = set_p & ~clr_p;
      en_s = set_s & ~clr_s;
      sec_req = '0; pri_req = '0;
      wr(pa(3, 0), 32'hFFFF_FFFF); wr(pa(3, 1), 32'hFF); wr(10'h98, 32'hFFFF_FFFF);
      clear_all();
      wr(pa(2, 0), set_p[31:0]); wr(pa(2, 1), 32'(set_p[39:32]));
      wr(pa(3, 0), clr_p[31:0]); wr(pa(3, 1), 32'(clr_p[39:32]));
      wr(10'h90, set_s); wr(10'h98, clr_s);
      @(negedge clk); sec_req = rs; pri_req = rp;
      @(negedge clk); sec_req = '0; pri_req = '0;
      repeat (3) @(negedge clk);
      pend_p = {rp, |(rs & en_s)};
      check("R4 random irq", 64'(cpu_irq), 64'(|(pend_p & en_p)));
      rd(10'h40, rv); check("R5 random pidx", 64'(rv), 64'(lowest(pend_p & en_p)));
      rd(10'h80, rv); check("R6 random sec status", 64'(rv), 64'(rs & en_s));
      rd(pa(2, 1), rv); check("R3 random en upper", 64'(rv), 64'(en_p[39:32]));
      rd(10'h90, rv); check("R7 random sec en", 64'(rv), 64'(en_s));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule